// File: doc/BRIEF.md
# Channel Interleave Target Decoder

This block sits behind one home agent's address path. A physical address that has already been routed to the agent is matched against a small set of target-decode windows, each described by a base and a limit. The first window that contains the address supplies the interleave parameters: socket ways, channel ways, the socket and channel granularities, a list of channel targets and one address offset for each channel. From these the block picks the memory channel and works out the address as seen on that channel.

The channel is chosen by taking the cache-line number of the address, optionally shifting it one further bit (shift-up), dividing by the socket ways, optionally folding in an XOR hash of address bit pairs, and reducing the result modulo the channel ways. The result indexes the rule's target list. The channel-local address is found in two granularity-aware steps. Each step removes one interleave level and keeps the address bits below its granularity. Every unusable case is reported through a failure code: no window matches, three-way channel interleave, way counts the block does not support, a bad target index, a bad channel, or an offset larger than the address.

The block is a two-stage pipeline. The first stage does the window match and the channel pick. The second stage does the offset and address arithmetic. The configuration inputs are held static while addresses flow.

Top module: `cid_decoder`

## Requirements
- R1: A rule hits when base <= address < limit. When several rules hit, the lowest-numbered one is used. When no rule hits, out_fail = 1.
- R2: A hit rule whose channel ways equal 3 gives out_fail = 2.
- R3: A hit rule whose socket ways or channel ways are not one of 1, 2, 4 or 8 (and the channel ways are not 3) gives out_fail = 3.
- R4: The channel index is built in this order:
  1. Take address >> 6.
  2. Shift right one more bit when shift_up = 1.
  3. Divide by the socket ways.
  4. When hash_en = 1, XOR in the 2-bit fields at address bits 13:12, 15:14, …, 27:26.
  5. Take the result modulo the channel ways.

  The channel is then entry [index] of the rule's target list.
- R5: An index that is not below the rule's target count gives out_fail = 4.
- R6: A selected channel that is not below num_chan gives out_fail = 5.
- R7: The offset for (channel, rule) is stored in chan_off at bit (channel*NRULE + rule)*AW. When that offset is greater than the address, out_fail = 6.
- R8: The granularity codes map to shifts as follows: 0 gives 6 (7 with shift_up), 1 gives 8, 2 gives 12, 3 gives 30. The channel address is computed in two steps:
  1. t = (((addr - off) >> ss) / socket ways) << ss, OR the address bits below ss.
  2. The result is ((t >> cs) / channel ways) << cs, OR the address bits below cs.

  Here ss is the socket shift and cs is the channel shift.
- R9: out_vld follows in_vld two clock edges later. Failure checks are applied in the order of R1, R2, R3, R5, R6, R7, and the first that applies sets the code. out_fail is 0 on success. out_chan and out_chan_addr are 0 whenever out_vld = 0 or out_fail != 0.
- R10: While rst_n is low, out_vld = 0 and out_fail = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Address valid |
| in_addr | input | AW | Physical address |
| shift_up | input | 1 | Channel shift-up enable |
| hash_en | input | 1 | Channel hash enable |
| num_chan | input | NCHW | Number of channels present |
| rule_base | input | NRULE*AW | Window base per rule |
| rule_limit | input | NRULE*AW | Window limit (exclusive) per rule |
| rule_sock_ways | input | NRULE*4 | Socket ways per rule |
| rule_chan_ways | input | NRULE*4 | Channel ways per rule |
| rule_sock_gran | input | NRULE*2 | Socket granularity code per rule |
| rule_chan_gran | input | NRULE*2 | Channel granularity code per rule |
| rule_ntgt | input | NRULE*NTW | Target list length per rule |
| rule_tgt | input | NRULE*NTGT*CIDW | Target channel list, entry (rule*NTGT + index) |
| chan_off | input | NCH*NRULE*AW | Offset per (channel, rule) |
| out_vld | output | 1 | Result valid |
| out_fail | output | 3 | Failure code, 0 for success |
| out_chan | output | CIDW | Selected channel |
| out_chan_addr | output | AW | Channel-local address |

## Verification
Two things can happen in the same cycle. One address can sit in the arithmetic stage, doing its offset subtraction and interleave squeeze, while the next address is being window-matched and picking its channel. The bench provokes this by issuing addresses back to back that hit different rules, with different failure outcomes one after another. A behavioural model computes each result with true division and modulo and delays it by two cycles. The model is compared against the ports on every cycle, so a value leaking from one transaction into its neighbour shows up as a mismatch. Shift-up and hashing are also enabled together, so that the index path and the 64-byte granularity shift are both changed at once.

// File: rtl/cid_pkg.sv
package cid_pkg;
  localparam int WAYS_W = 4;
  localparam int GRAN_W = 2;

  typedef enum logic [2:0] {
    FAIL_NONE      = 3'd0,
    FAIL_NO_RULE   = 3'd1,
    FAIL_THREE_WAY = 3'd2,
    FAIL_WAYS      = 3'd3,
    FAIL_INDEX     = 3'd4,
    FAIL_CHAN      = 3'd5,
    FAIL_UNDERFLOW = 3'd6
  } fail_e;

  // granularity code to bit shift
  function automatic logic [4:0] gran_shift(logic [GRAN_W-1:0] code, logic up);
    case (code)
      2'd0:    gran_shift = up ? 5'd7 : 5'd6;
      2'd1:    gran_shift = 5'd8;
      2'd2:    gran_shift = 5'd12;
      default: gran_shift = 5'd30;
    endcase
  endfunction

  function automatic logic ways_ok(logic [WAYS_W-1:0] w);
    ways_ok = (w == 4'd1) || (w == 4'd2) || (w == 4'd4) || (w == 4'd8);
  endfunction

  function automatic logic [1:0] ways_log2(logic [WAYS_W-1:0] w);
    if (w[3])      ways_log2 = 2'd3;
    else if (w[2]) ways_log2 = 2'd2;
    else if (w[1]) ways_log2 = 2'd1;
    else           ways_log2 = 2'd0;
  endfunction
endpackage

// File: rtl/cid_rule_match.sv
module cid_rule_match #(
  parameter int AW    = 46,
  parameter int NRULE = 8,
  localparam int RIW  = $clog2(NRULE)
) (
  input  logic [AW-1:0]       addr,
  input  logic [NRULE*AW-1:0] rule_base,
  input  logic [NRULE*AW-1:0] rule_limit,
  output logic                hit,
  output logic [RIW-1:0]      idx
);
  logic [NRULE-1:0] in_win;

  for (genvar g = 0; g < NRULE; g++) begin : g_win
    assign in_win[g] = (addr >= rule_base[g*AW +: AW]) && (addr < rule_limit[g*AW +: AW]);
  end

  // lowest-numbered window wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NRULE - 1; i >= 0; i--) begin
      if (in_win[i]) begin
        hit = 1'b1;
        idx = RIW'(i);
      end
    end
  end
endmodule

// File: rtl/cid_index_stage.sv
module cid_index_stage
  import cid_pkg::*;
#(
  parameter int AW    = 46,
  parameter int NRULE = 8,
  parameter int NTGT  = 8,
  parameter int NCH   = 4,
  parameter int CIDW  = 3,
  localparam int RIW  = $clog2(NRULE),
  localparam int TIW  = $clog2(NTGT),
  localparam int NTW  = TIW + 1,
  localparam int NCHW = $clog2(NCH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_vld,
  input  logic [AW-1:0]             in_addr,
  input  logic                      shift_up,
  input  logic                      hash_en,
  input  logic [NCHW-1:0]           num_chan,
  input  logic [NRULE*WAYS_W-1:0]   rule_sock_ways,
  input  logic [NRULE*WAYS_W-1:0]   rule_chan_ways,
  input  logic [NRULE*NTW-1:0]      rule_ntgt,
  input  logic [NRULE*NTGT*CIDW-1:0] rule_tgt,
  input  logic                      m_hit,
  input  logic [RIW-1:0]            m_idx,
  output logic                      s1_vld,
  output logic [AW-1:0]             s1_addr,
  output logic [RIW-1:0]            s1_rule,
  output logic [CIDW-1:0]           s1_chan,
  output fail_e                     s1_fail
);
  // cache-line index, shift-up, socket divide, hash, channel modulo
  function automatic logic [TIW-1:0] chan_index(logic [AW-1:0] a, logic up, logic hsh,
                                               logic [1:0] swl, logic [1:0] cwl);
    logic [AW-1:0] v;
    v = a >> 6;
    if (up) v = v >> 1;
    v = v >> swl;
    if (hsh) begin
      for (int b = 12; b < 28; b += 2) v[1:0] = v[1:0] ^ a[b +: 2];
    end
    v = v & ~({AW{1'b1}} << cwl);
    return v[TIW-1:0];
  endfunction

  logic [WAYS_W-1:0] sw, cw;
  logic [NTW-1:0]    nt;
  logic [TIW-1:0]    tidx;
  logic [CIDW-1:0]   tgt;
  fail_e             fail_d;

  always_comb begin
    sw   = rule_sock_ways[int'(m_idx)*WAYS_W +: WAYS_W];
    cw   = rule_chan_ways[int'(m_idx)*WAYS_W +: WAYS_W];
    nt   = rule_ntgt[int'(m_idx)*NTW +: NTW];
    tidx = chan_index(in_addr, shift_up, hash_en, ways_log2(sw), ways_log2(cw));
    tgt  = rule_tgt[(int'(m_idx)*NTGT + int'(tidx))*CIDW +: CIDW];
    if (!m_hit)                            fail_d = FAIL_NO_RULE;
    else if (cw == 4'd3)                   fail_d = FAIL_THREE_WAY;
    else if (!ways_ok(sw) || !ways_ok(cw)) fail_d = FAIL_WAYS;
    else if (NTW'(tidx) >= nt)             fail_d = FAIL_INDEX;
    else if (int'(tgt) >= int'(num_chan))  fail_d = FAIL_CHAN;
    else                                   fail_d = FAIL_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_addr <= '0;
      s1_rule <= '0;
      s1_chan <= '0;
      s1_fail <= FAIL_NONE;
    end else begin
      s1_vld  <= in_vld;
      s1_addr <= in_addr;
      s1_rule <= m_idx;
      s1_chan <= tgt;
      s1_fail <= in_vld ? fail_d : FAIL_NONE;
    end
  end
endmodule

// File: rtl/cid_addr_stage.sv
module cid_addr_stage
  import cid_pkg::*;
#(
  parameter int AW    = 46,
  parameter int NRULE = 8,
  parameter int NCH   = 4,
  parameter int CIDW  = 3,
  localparam int RIW  = $clog2(NRULE)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shift_up,
  input  logic [NRULE*WAYS_W-1:0] rule_sock_ways,
  input  logic [NRULE*WAYS_W-1:0] rule_chan_ways,
  input  logic [NRULE*GRAN_W-1:0] rule_sock_gran,
  input  logic [NRULE*GRAN_W-1:0] rule_chan_gran,
  input  logic [NCH*NRULE*AW-1:0] chan_off,
  input  logic                    s1_vld,
  input  logic [AW-1:0]           s1_addr,
  input  logic [RIW-1:0]          s1_rule,
  input  logic [CIDW-1:0]         s1_chan,
  input  fail_e                   s1_fail,
  output logic                    out_vld,
  output logic [2:0]              out_fail,
  output logic [CIDW-1:0]         out_chan,
  output logic [AW-1:0]           out_chan_addr
);
  // remove one interleave level, keeping the original bits below sh
  function automatic logic [AW-1:0] squeeze(logic [AW-1:0] val, logic [AW-1:0] orig,
                                            logic [4:0] sh, logic [1:0] wl);
    logic [AW-1:0] keep;
    keep = ~({AW{1'b1}} << sh);
    return (((val >> sh) >> wl) << sh) | (orig & keep);
  endfunction

  logic [AW-1:0] off, step1, caddr;
  logic [4:0]    ss, cs;
  logic [1:0]    swl, cwl;
  fail_e         fail_d;

  always_comb begin
    off = '0;
    if (int'(s1_chan) < NCH)
      off = chan_off[(int'(s1_chan)*NRULE + int'(s1_rule))*AW +: AW];
    ss    = gran_shift(rule_sock_gran[int'(s1_rule)*GRAN_W +: GRAN_W], shift_up);
    cs    = gran_shift(rule_chan_gran[int'(s1_rule)*GRAN_W +: GRAN_W], shift_up);
    swl   = ways_log2(rule_sock_ways[int'(s1_rule)*WAYS_W +: WAYS_W]);
    cwl   = ways_log2(rule_chan_ways[int'(s1_rule)*WAYS_W +: WAYS_W]);
    step1 = squeeze(s1_addr - off, s1_addr, ss, swl);
    caddr = squeeze(step1, s1_addr, cs, cwl);
    if (s1_fail == FAIL_NONE && off > s1_addr) fail_d = FAIL_UNDERFLOW;
    else                                      fail_d = s1_fail;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld       <= 1'b0;
      out_fail      <= '0;
      out_chan      <= '0;
      out_chan_addr <= '0;
    end else begin
      out_vld       <= s1_vld;
      out_fail      <= s1_vld ? 3'(fail_d) : 3'd0;
      out_chan      <= (s1_vld && fail_d == FAIL_NONE) ? s1_chan : '0;
      out_chan_addr <= (s1_vld && fail_d == FAIL_NONE) ? caddr : '0;
    end
  end
endmodule

// File: rtl/cid_decoder.sv
module cid_decoder
  import cid_pkg::*;
#(
  parameter int AW    = 46,
  parameter int NRULE = 8,
  parameter int NTGT  = 8,
  parameter int NCH   = 4,
  parameter int CIDW  = 3,
  localparam int RIW  = $clog2(NRULE),
  localparam int NTW  = $clog2(NTGT) + 1,
  localparam int NCHW = $clog2(NCH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_vld,
  input  logic [AW-1:0]              in_addr,
  input  logic                       shift_up,
  input  logic                       hash_en,
  input  logic [NCHW-1:0]            num_chan,
  input  logic [NRULE*AW-1:0]        rule_base,
  input  logic [NRULE*AW-1:0]        rule_limit,
  input  logic [NRULE*4-1:0]         rule_sock_ways,
  input  logic [NRULE*4-1:0]         rule_chan_ways,
  input  logic [NRULE*2-1:0]         rule_sock_gran,
  input  logic [NRULE*2-1:0]         rule_chan_gran,
  input  logic [NRULE*NTW-1:0]       rule_ntgt,
  input  logic [NRULE*NTGT*CIDW-1:0] rule_tgt,
  input  logic [NCH*NRULE*AW-1:0]    chan_off,
  output logic                       out_vld,
  output logic [2:0]                 out_fail,
  output logic [CIDW-1:0]            out_chan,
  output logic [AW-1:0]              out_chan_addr
);
  logic            m_hit;
  logic [RIW-1:0]  m_idx;
  logic            s1_vld;
  logic [AW-1:0]   s1_addr;
  logic [RIW-1:0]  s1_rule;
  logic [CIDW-1:0] s1_chan;
  fail_e           s1_fail;

  cid_rule_match #(.AW(AW), .NRULE(NRULE)) u_match (
    .addr(in_addr), .rule_base(rule_base), .rule_limit(rule_limit),
    .hit(m_hit), .idx(m_idx)
  );

  cid_index_stage #(.AW(AW), .NRULE(NRULE), .NTGT(NTGT), .NCH(NCH), .CIDW(CIDW)) u_idx (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_addr(in_addr),
    .shift_up(shift_up), .hash_en(hash_en), .num_chan(num_chan),
    .rule_sock_ways(rule_sock_ways), .rule_chan_ways(rule_chan_ways),
    .rule_ntgt(rule_ntgt), .rule_tgt(rule_tgt),
    .m_hit(m_hit), .m_idx(m_idx),
    .s1_vld(s1_vld), .s1_addr(s1_addr), .s1_rule(s1_rule),
    .s1_chan(s1_chan), .s1_fail(s1_fail)
  );

  cid_addr_stage #(.AW(AW), .NRULE(NRULE), .NCH(NCH), .CIDW(CIDW)) u_addr (
    .clk(clk), .rst_n(rst_n), .shift_up(shift_up),
    .rule_sock_ways(rule_sock_ways), .rule_chan_ways(rule_chan_ways),
    .rule_sock_gran(rule_sock_gran), .rule_chan_gran(rule_chan_gran),
    .chan_off(chan_off),
    .s1_vld(s1_vld), .s1_addr(s1_addr), .s1_rule(s1_rule),
    .s1_chan(s1_chan), .s1_fail(s1_fail),
    .out_vld(out_vld), .out_fail(out_fail), .out_chan(out_chan),
    .out_chan_addr(out_chan_addr)
  );
endmodule

// File: rtl/cid_decoder_chk.sv
module cid_decoder_chk #(
  parameter int AW   = 46,
  parameter int CIDW = 3,
  parameter int NCHW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_vld,
  input logic            s1_vld,
  input logic [NCHW-1:0] num_chan,
  input logic            out_vld,
  input logic [2:0]      out_fail,
  input logic [CIDW-1:0] out_chan,
  input logic [AW-1:0]   out_chan_addr
);
  // R9
  stage_one_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> s1_vld);
  // R9
  stage_two_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> out_vld);
  // R9
  no_ghost_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> !out_vld);
  // R9
  quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_vld || out_fail != 3'd0) |-> (out_chan == '0 && out_chan_addr == '0));
  // R9
  fail_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fail != 3'd7);
  // R6
  chan_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_fail == 3'd0) |-> (int'(out_chan) < int'($past(num_chan, 2))));
endmodule

bind cid_decoder cid_decoder_chk #(.AW(AW), .CIDW(CIDW), .NCHW(NCHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .s1_vld(s1_vld), .num_chan(num_chan),
  .out_vld(out_vld), .out_fail(out_fail), .out_chan(out_chan),
  .out_chan_addr(out_chan_addr)
);

// File: tb/sim_cid_decoder.sv
`timescale 1ns/1ps
module sim_cid_decoder;
  localparam int AW = 46, NRULE = 8, NTGT = 8, NCH = 4, CIDW = 3;
  localparam int NTW = 4, NCHW = 3;

  typedef struct {
    bit      v;
    int      fail;
    int      ch;
    longint  ca;
    string   tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic shift_up = 1'b0, hash_en = 1'b0;
  logic [NCHW-1:0] num_chan = 3'd4;
  logic [NRULE*AW-1:0] rule_base, rule_limit;
  logic [NRULE*4-1:0] rule_sock_ways, rule_chan_ways;
  logic [NRULE*2-1:0] rule_sock_gran, rule_chan_gran;
  logic [NRULE*NTW-1:0] rule_ntgt;
  logic [NRULE*NTGT*CIDW-1:0] rule_tgt;
  logic [NCH*NRULE*AW-1:0] chan_off;
  logic out_vld;
  logic [2:0] out_fail;
  logic [CIDW-1:0] out_chan;
  logic [AW-1:0] out_chan_addr;

  always #2 clk = ~clk;

  cid_decoder u0 (.*);

  longint bbase[NRULE], blim[NRULE], boff[NCH][NRULE];
  int bsw[NRULE], bcw[NRULE], bsg[NRULE], bcg[NRULE], bnt[NRULE];
  int btgt[NRULE][NTGT];
  int total = 0, bad = 0;
  exp_t e1, e2;

  function automatic int gshift(int code, bit up);
    if (code == 0) return up ? 7 : 6;
    if (code == 1) return 8;
    if (code == 2) return 12;
    return 30;
  endfunction

  function automatic bit pow2w(int w);
    return w == 1 || w == 2 || w == 4 || w == 8;
  endfunction

  function automatic exp_t model(longint a, bit up, bit hsh, int nch);
    exp_t e;
    int r = -1;
    longint idx, t, off;
    int ss, cs, ch;
    e.v = 1; e.fail = 0; e.ch = 0; e.ca = 0; e.tag = "R4,R8";
    for (int i = 0; i < NRULE; i++)
      if (r < 0 && a >= bbase[i] && a < blim[i]) r = i;
    if (r < 0) begin e.fail = 1; e.tag = "R1"; return e; end
    if (bcw[r] == 3) begin e.fail = 2; e.tag = "R2"; return e; end
    if (!pow2w(bsw[r]) || !pow2w(bcw[r])) begin e.fail = 3; e.tag = "R3"; return e; end
    idx = a >> 6;
    if (up) idx = idx >> 1;
    idx = idx / bsw[r];
    if (hsh) for (int b = 12; b <= 26; b += 2) idx = idx ^ ((a >> b) & 3);
    idx = idx % bcw[r];
    if (idx >= bnt[r]) begin e.fail = 4; e.tag = "R5"; return e; end
    ch = btgt[r][int'(idx)];
    if (ch >= nch) begin e.fail = 5; e.tag = "R6"; return e; end
    off = boff[ch][r];
    if (off > a) begin e.fail = 6; e.tag = "R7"; return e; end
    ss = gshift(bsg[r], up);
    cs = gshift(bcg[r], up);
    t = (((a - off) >> ss) / bsw[r]) << ss;
    t = t | (a & ((64'd1 << ss) - 1));
    t = ((t >> cs) / bcw[r]) << cs;
    t = t | (a & ((64'd1 << cs) - 1));
    e.ch = ch; e.ca = t;
    return e;
  endfunction

  task automatic compare();
    total++;
    if (e2.v) begin
      if (out_vld !== 1'b1 || int'(out_fail) != e2.fail || int'(out_chan) != e2.ch ||
          longint'(out_chan_addr) != e2.ca) begin
        bad++;
        $display("FAIL %s: got vld=%0d fail=%0d ch=%0d ca=%h exp vld=1 fail=%0d ch=%0d ca=%h",
                 e2.tag, out_vld, out_fail, out_chan, out_chan_addr, e2.fail, e2.ch, e2.ca);
      end
    end else if (out_vld !== 1'b0 || out_fail != 0 || out_chan != 0 || out_chan_addr != 0) begin
      bad++;
      $display("FAIL R9 idle: got vld=%0d fail=%0d ch=%0d ca=%h exp all zero",
               out_vld, out_fail, out_chan, out_chan_addr);
    end
  endtask

  // one cycle: check the result due now, then issue the next address or idle
  task automatic step(bit v, longint a);
    @(negedge clk);
    compare();
    e2 = e1;
    in_vld = v;
    in_addr = AW'(a);
    if (v) e1 = model(a, shift_up, hash_en, int'(num_chan));
    else begin e1.v = 0; e1.tag = "R9"; end
  endtask

  initial begin
    // rule set
    bbase = '{64'h0, 64'h4000_0000, 64'h8000_0000, 64'hC000_0000,
              64'h1_0000_0000, 64'h2_0000_0000, 64'h3_0000_0000, 64'h0};
    blim  = '{64'h4000_0000, 64'h8000_0000, 64'hC000_0000, 64'h1_0000_0000,
              64'h2_0000_0000, 64'h3_0000_0000, 64'h4_0000_0000, 64'h1000_0000};
    bsw = '{1, 2, 1, 5, 1, 8, 1, 1};
    bcw = '{2, 4, 3, 2, 4, 8, 1, 1};
    bsg = '{0, 2, 0, 0, 1, 3, 0, 0};
    bcg = '{0, 1, 0, 0, 1, 0, 0, 0};
    bnt = '{2, 4, 3, 2, 2, 8, 1, 1};
    for (int r = 0; r < NRULE; r++)
      for (int k = 0; k < NTGT; k++) btgt[r][k] = k % 4;
    btgt[1] = '{1, 2, 3, 0, 0, 0, 0, 0};
    for (int k = 0; k < NTGT; k++) btgt[5][k] = k;
    btgt[6][0] = 2;
    btgt[7][0] = 3;
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < NRULE; r++) boff[c][r] = bbase[r] + 64'(c) * 64'h40;
    boff[2][6] = 64'h3_8000_0000;
    for (int r = 0; r < NRULE; r++) begin
      rule_base[r*AW +: AW] = AW'(bbase[r]);
      rule_limit[r*AW +: AW] = AW'(blim[r]);
      rule_sock_ways[r*4 +: 4] = 4'(bsw[r]);
      rule_chan_ways[r*4 +: 4] = 4'(bcw[r]);
      rule_sock_gran[r*2 +: 2] = 2'(bsg[r]);
      rule_chan_gran[r*2 +: 2] = 2'(bcg[r]);
      rule_ntgt[r*NTW +: NTW] = NTW'(bnt[r]);
      for (int k = 0; k < NTGT; k++) rule_tgt[(r*NTGT + k)*CIDW +: CIDW] = CIDW'(btgt[r][k]);
      for (int c = 0; c < NCH; c++) chan_off[(c*NRULE + r)*AW +: AW] = AW'(boff[c][r]);
    end
    e1.v = 0; e1.tag = "R9"; e2 = e1;

    repeat (3) @(negedge clk);
    // R10 reset state
    total++;
    if (out_vld !== 1'b0 || out_fail !== 3'd0) begin
      bad++;
      $display("FAIL R10: got vld=%0d fail=%0d exp vld=0 fail=0", out_vld, out_fail);
    end
    rst_n = 1'b1;

    begin
      longint dir[16] = '{64'h0, 64'h40, 64'h1234_5678, 64'h4000_0000, 64'h7FFF_FFFF,
                          64'h8000_0000, 64'hC000_0040, 64'h1_0000_0000, 64'h1_0000_0080,
                          64'h2_0000_0200, 64'h2_0000_0800, 64'h3_0000_0000,
                          64'h3_8000_0010, 64'h4_0000_0000, 64'h3FFF_FFFF_FFFF,
                          64'h0FFF_FFC0};
      longint seed = 64'h1D2C_3B4A_5968_7788;
      for (int mode = 0; mode < 4; mode++) begin
        repeat (3) step(0, 0);
        shift_up = mode[0];
        hash_en = mode[1];
        num_chan = (mode == 3) ? 3'd3 : 3'd4;
        foreach (dir[i]) step(1, dir[i]);
        for (int n = 0; n < 80; n++) begin
          seed = seed ^ (seed << 13);
          seed = seed ^ (seed >> 7);
          seed = seed ^ (seed << 17);
          step((n % 9) != 4, (seed & 64'h7FFF_FFFF_FFFF_FFFF) % 64'h4_8000_0000);
        end
      end
      repeat (3) step(0, 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R9 watchdog: got no end exp end of run");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule